// File: doc/BRIEF.md
# Ready-Gated System Clock Switch

This block picks the system clock from three sources: the internal high-speed oscillator, the external high-speed oscillator and the PLL. Software writes a 2-bit source choice. The switch takes place only once the chosen source reports ready. A glitch-free gated mux then moves the system clock to it. The old source is gated off on its own falling edge before the new source is gated on at its falling edge. A status field reports the source that is actually driving the output.

A clock-failure monitor is represented by a one-cycle input pulse. When the monitor is armed and the external oscillator fails, the block does four things. It raises a sticky non-maskable interrupt request. It asserts an oscillator shut-off. It asynchronously clears the gating stages of every source that depends on the external clock. It forces both the selection and the active source back to the internal oscillator, whose clock always runs. A wake pulse from a low-power state also restores the internal oscillator as the source.

All control logic runs on the internal oscillator clock. That clock runs at 8 MHz after reset. The bench runs it faster.

Top module: `sysclk_switch`

## Requirements
- R1: Source codes are 0 for internal, 1 for external and 2 for PLL. The status output `sws` uses the same codes, so read as a byte shifted left by two it gives 0x00, 0x04 or 0x08. `sys_clk` runs at the frequency of the source that `sws` names.
- R2: A selected source becomes active only while it is ready. If it is not ready, the current source stays active and the request stays pending. The switch completes once the source becomes ready.
- R3: A write of code 3 is ignored, and the selection and active source stay as they were.
- R4: After reset and after a `wake` pulse, the internal oscillator is both selected and active, and `hsi_on` is high.
- R5: A `css_fail` pulse with `css_en` high has this effect when the external clock is in use directly, or through the PLL with `pll_from_hse` set. The active source returns to the internal oscillator and `hse_off` rises.
- R6: A `css_fail` pulse with `css_en` high sets `nmi_req`. With `css_en` low, the pulse has no effect.
- R7: `nmi_req` and `hse_off` stay set until a `nmi_clr` pulse clears them. If a failure and a clear arrive in the same cycle, the flags stay set.
- R8: At most one source gate is open at any time. During a normal switch, no high pulse on `sys_clk` is shorter than a high phase of the source clocks.
- R9: `sws` changes only after the new source has been gated onto `sys_clk`. A few cycles after a write, it still reports the old source.
- R10: While `hse_off` is high, the external source counts as not ready, so a request for it stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hsi | input | 1 | Internal high-speed clock; also clocks the control logic |
| clk_hse | input | 1 | External high-speed clock |
| clk_pll | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr | input | 1 | Source selection write strobe |
| sw_data | input | 2 | Source code to write |
| hse_rdy | input | 1 | External oscillator stable |
| pll_rdy | input | 1 | PLL locked |
| pll_from_hse | input | 1 | PLL is fed from the external oscillator |
| css_en | input | 1 | Arms the clock-failure response |
| css_fail | input | 1 | One-cycle failure report from the monitor |
| wake | input | 1 | One-cycle wake from stop or standby |
| nmi_clr | input | 1 | Write-one-to-clear pulse for the failure flag |
| sys_clk | output | 1 | Gated system clock |
| sws | output | 2 | Source actually driving `sys_clk` |
| hsi_on | output | 1 | Keeps the internal oscillator running |
| hse_off | output | 1 | Shuts off the external oscillator after a failure |
| nmi_req | output | 1 | Sticky clock-failure interrupt request |

## Verification
The assertions assume the following about the inputs. Every control input, including the ready flags and the pulses, is synchronous to `clk_hsi`. The internal oscillator clock never stops. The runt-pulse property applies only to switches that software requests, not to the asynchronous clear after a failure or a wake. The stimulus changes inputs only at falling edges of `clk_hsi` and allows each switch to settle. The runt-pulse width measurement is turned on only during the stimulus table, so failure and wake cases, which may legitimately cut a running clock, fall outside it. In the failure case the external clock is held low before the failure pulse arrives.

// File: rtl/sysclk_switch.sv
module sysclk_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_hsi,
  input  logic       clk_hse,
  input  logic       clk_pll,
  input  logic       rst_n,
  input  logic       sw_wr,
  input  logic [1:0] sw_data,
  input  logic       hse_rdy,
  input  logic       pll_rdy,
  input  logic       pll_from_hse,
  input  logic       css_en,
  input  logic       css_fail,
  input  logic       wake,
  input  logic       nmi_clr,
  output logic       sys_clk,
  output logic [1:0] sws,
  output logic       hsi_on,
  output logic       hse_off,
  output logic       nmi_req
);
  localparam int NSRC = 3;
  localparam logic [1:0] SRC_HSI = 2'd0;
  localparam logic [1:0] SRC_HSE = 2'd1;
  localparam logic [1:0] SRC_PLL = 2'd2;

  logic [1:0] sw, tgt;
  logic hse_kill, nmi_q, wake_q;
  logic hse_ok, pll_ok, sw_ok, fail_hit, uses_hse;
  logic [NSRC-1:0] clk_v, en, want, chain_rst_n, en_s1, en_s2;

  assign clk_v    = {clk_pll, clk_hse, clk_hsi};
  assign hse_ok   = hse_rdy & ~hse_kill;
  assign pll_ok   = pll_rdy & ~(pll_from_hse & hse_kill);
  assign fail_hit = css_en & css_fail;
  assign uses_hse = (sw == SRC_HSE) || (tgt == SRC_HSE) ||
                    (((sw == SRC_PLL) || (tgt == SRC_PLL)) && pll_from_hse);

  always_comb begin
    case (sw)
      SRC_HSE: sw_ok = hse_ok;
      SRC_PLL: sw_ok = pll_ok;
      default: sw_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk_hsi or negedge rst_n) begin
    if (!rst_n) begin
      sw       <= SRC_HSI;
      tgt      <= SRC_HSI;
      hse_kill <= 1'b0;
      nmi_q    <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      wake_q <= wake;
      if (wake || (fail_hit && uses_hse)) begin
        sw  <= SRC_HSI;
        tgt <= SRC_HSI;
      end else begin
        if (sw_wr && sw_data != 2'd3) sw <= sw_data;
        if (sw_ok) tgt <= sw;
      end
      if (fail_hit)     hse_kill <= 1'b1;
      else if (nmi_clr) hse_kill <= 1'b0;
      if (fail_hit)     nmi_q <= 1'b1;
      else if (nmi_clr) nmi_q <= 1'b0;
    end
  end

  assign chain_rst_n[0] = rst_n;
  assign chain_rst_n[1] = rst_n & ~(hse_kill | wake_q);
  assign chain_rst_n[2] = rst_n & ~((hse_kill & pll_from_hse) | wake_q);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [SYNC_STAGES-1:0] sh;
    assign want[i] = (tgt == 2'(i)) && ((en & ~(3'b001 << i)) == 3'b000);
    always_ff @(negedge clk_v[i] or negedge chain_rst_n[i]) begin
      if (!chain_rst_n[i]) sh <= {SYNC_STAGES{i == 0}};
      else                 sh <= {sh[SYNC_STAGES-2:0], want[i]};
    end
    assign en[i] = sh[SYNC_STAGES-1];
  end

  assign sys_clk = |(clk_v & en);

  always_ff @(posedge clk_hsi or negedge rst_n) begin
    if (!rst_n) begin
      en_s1 <= 3'b001;
      en_s2 <= 3'b001;
    end else begin
      en_s1 <= en;
      en_s2 <= en_s1;
    end
  end

  assign sws     = en_s2[2] ? SRC_PLL : (en_s2[1] ? SRC_HSE : SRC_HSI);
  assign hsi_on  = (tgt == SRC_HSI) | en_s2[0];
  assign hse_off = hse_kill;
  assign nmi_req = nmi_q;

  AST_ONE_GATE_OPEN: assert property (@(posedge clk_hsi) disable iff (!rst_n) $onehot0(en)); // R8
  AST_PLL_NEEDS_READY: assert property (@(posedge clk_hsi) disable iff (!rst_n)
    (tgt == SRC_PLL && $past(tgt) != SRC_PLL) |-> $past(pll_ok)); // R2
  AST_HSE_NEEDS_READY: assert property (@(posedge clk_hsi) disable iff (!rst_n)
    (tgt == SRC_HSE && $past(tgt) != SRC_HSE) |-> $past(hse_ok)); // R10
  AST_FAIL_FALLBACK: assert property (@(posedge clk_hsi) disable iff (!rst_n)
    (fail_hit && uses_hse) |=> (tgt == SRC_HSI && hse_off)); // R5
  AST_NMI_STICKY: assert property (@(posedge clk_hsi) disable iff (!rst_n)
    (nmi_req && !nmi_clr) |=> nmi_req); // R7
  AST_RSV_IGNORED: assert property (@(posedge clk_hsi) disable iff (!rst_n)
    (sw_wr && sw_data == 2'd3 && !wake && !fail_hit) |=> $stable(sw)); // R3
endmodule

// File: tb/sysclk_switch_bench.sv
`timescale 1ns/1ps
module sysclk_switch_bench;
  logic clk_hsi = 0, clk_hse = 0, clk_pll = 0, rst_n = 0;
  logic sw_wr = 0, hse_rdy = 0, pll_rdy = 0, pll_from_hse = 0;
  logic css_en = 0, css_fail = 0, wake = 0, nmi_clr = 0;
  logic [1:0] sw_data = 0;
  logic sys_clk, hsi_on, hse_off, nmi_req;
  logic [1:0] sws;
  logic hse_run = 1, glitch_on = 0, done = 0;
  int total = 0, bad = 0, edges = 0, runts = 0;
  realtime t_rise = 0;

  sysclk_switch u_sysclk_switch (.*);

  always #2.5 clk_hsi = ~clk_hsi;
  always #3.5 clk_pll = ~clk_pll;
  initial forever begin #6; clk_hse = hse_run ? ~clk_hse : 1'b0; end

  always @(posedge sys_clk) edges++;
  always @(sys_clk) begin
    if (sys_clk) t_rise = $realtime;
    else if (glitch_on && ($realtime - t_rise) < 2.4) runts++;
  end

  // {sel, hse_rdy, pll_rdy, expected sws}
  localparam logic [5:0] VEC [9] = '{
    {2'd1,1'b1,1'b0,2'd1}, {2'd2,1'b1,1'b0,2'd1}, {2'd2,1'b1,1'b1,2'd2},
    {2'd0,1'b1,1'b1,2'd0}, {2'd2,1'b0,1'b1,2'd2}, {2'd1,1'b0,1'b1,2'd2},
    {2'd1,1'b1,1'b1,2'd1}, {2'd3,1'b1,1'b1,2'd1}, {2'd0,1'b0,1'b0,2'd0}};

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(string req, logic [1:0] src);
    int e0, got, want;
    @(negedge clk_hsi);
    e0 = edges;
    #420;
    got = edges - e0;
    want = (src == 2'd2) ? 60 : (src == 2'd1) ? 35 : 84;
    chk(req, (got >= want - 2 && got <= want + 2) ? want : got, want);
  endtask

  task automatic wr(logic [1:0] s);
    @(negedge clk_hsi); sw_wr = 1; sw_data = s;
    @(negedge clk_hsi); sw_wr = 0;
  endtask

  task automatic pulse_fail();
    @(negedge clk_hsi); css_fail = 1;
    @(negedge clk_hsi); css_fail = 0;
  endtask

  task automatic settle();
    repeat (70) @(negedge clk_hsi);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk_hsi);
    rst_n = 1;
    repeat (4) @(negedge clk_hsi);
    chk("R4 reset sws", sws, 0);
    chk("R4 reset hsi_on", hsi_on, 1);
    chk("R7 reset nmi", nmi_req, 0);
    chk("R7 reset hse_off", hse_off, 0);
    measure("R1 reset freq", 2'd0);

    glitch_on = 1;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk_hsi);
      hse_rdy = VEC[i][3]; pll_rdy = VEC[i][2];
      wr(VEC[i][5:4]);
      if (i == 0) begin
        repeat (2) @(negedge clk_hsi);
        chk("R9 early sws", sws, 0);
      end
      settle();
      chk((i == 1 || i == 5) ? "R2 pending sws" : (i == 7) ? "R3 reserved sws" : "R1 sws",
          sws, VEC[i][1:0]);
      measure("R9 freq matches sws", VEC[i][1:0]);
    end
    glitch_on = 0;
    chk("R8 runt pulses", runts, 0);

    hse_rdy = 1; wr(2'd1); settle();
    pulse_fail(); repeat (5) @(negedge clk_hsi);
    chk("R6 disarmed nmi", nmi_req, 0);
    chk("R6 disarmed sws", sws, 1);

    css_en = 1; hse_run = 0;
    pulse_fail(); settle();
    chk("R5 fallback sws", sws, 0);
    chk("R5 hse_off", hse_off, 1);
    chk("R6 nmi set", nmi_req, 1);
    measure("R5 fallback freq", 2'd0);

    wr(2'd1); settle();
    chk("R10 hse blocked", sws, 0);

    @(negedge clk_hsi); css_fail = 1; nmi_clr = 1;
    @(negedge clk_hsi); css_fail = 0; nmi_clr = 0;
    repeat (10) @(negedge clk_hsi);
    chk("R7 set wins", nmi_req, 1);
    @(negedge clk_hsi); nmi_clr = 1;
    @(negedge clk_hsi); nmi_clr = 0;
    chk("R7 cleared nmi", nmi_req, 0);
    chk("R7 cleared hse_off", hse_off, 0);
    hse_run = 1; wr(2'd0); settle();

    pll_from_hse = 1; pll_rdy = 1; wr(2'd2); settle();
    chk("R1 pll via hse", sws, 2);
    pulse_fail(); settle();
    chk("R5 pll via hse fallback", sws, 0);
    @(negedge clk_hsi); nmi_clr = 1;
    @(negedge clk_hsi); nmi_clr = 0; pll_from_hse = 0;

    wr(2'd2); settle();
    chk("R1 pll again", sws, 2);
    @(negedge clk_hsi); wake = 1;
    @(negedge clk_hsi); wake = 0;
    settle();
    chk("R4 wake sws", sws, 0);
    chk("R4 wake hsi_on", hsi_on, 1);
    measure("R4 wake freq", 2'd0);

    finish_up();
  end
endmodule